// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Line-Status Flag

This block receives asynchronous serial characters on a single input line. The line is resynchronised to the core clock and then sampled once per tick of an external oversampling tick, which runs at sixteen ticks per bit. A falling edge on the idle line starts a character. The block checks the start bit at its middle, then collects seven or eight data bits, least significant bit first, and an optional parity bit. It checks only the first stop bit. A good character goes into a single holding register and raises a ready flag. The parity bit is passed through as received and is not judged.

One status output changes meaning with the operating mode. In normal operation it is a sticky framing-error flag. A bad stop bit sets it. The next good character or a configuration write clears it, and a data read does not. While the block is asleep, it flags receiver activity instead: any transition on the line sets it. Going to sleep clears the holding register, the parity bit, the ready flag and the status flag, and the receiver stays idle until sleep is lifted.

Top module: `serial_rx_frame`

## Requirements
- R1: After reset, `rx_ready`, `rx_status` and `rx_par` are 0 and `rx_data` is all zeros.
- R2: With `cfg_word8`=1 and `cfg_par_en`=0, a character is a low start bit, then eight data bits least significant first, then a high stop bit, each lasting 16 ticks. After the stop bit is sampled, `rx_data` holds the character and `rx_ready` is 1.
- R3: With `cfg_word8`=0, seven data bits are received into `rx_data[6:0]`, and `rx_data[7]` reads 0.
- R4: With `cfg_par_en`=1, one extra bit follows the data bits and appears on `rx_par`, whatever its value. The character is accepted even when the parity is wrong. With parity disabled, `rx_par` reads 0.
- R5: A low pulse that has ended before the middle of the start bit is ignored. `rx_ready` stays 0 and `rx_data` is unchanged.
- R6: A 0 sampled in the first stop-bit position sets `rx_status`. It leaves `rx_ready` and `rx_data` unchanged, and the receiver goes straight back to looking for a start bit.
- R7: In normal mode, `rx_status` stays set through a `rd_stb` pulse and is cleared when the next correctly framed character is received.
- R8: A one-cycle `cfg_wr_stb` pulse clears `rx_status` when no set event falls in the same cycle.
- R9: Only one stop bit is required, so characters sent back to back with a single stop bit are all received.
- R10: A `rd_stb` pulse clears `rx_ready` and leaves `rx_data` unchanged. If a character completes in the same cycle as the strobe, `rx_ready` is set.
- R11: A rising `cfg_sleep` clears `rx_ready`, `rx_data`, `rx_par` and `rx_status`. While `cfg_sleep` is 1, no character is received.
- R12: While `cfg_sleep` is 1, any transition on `rx_line` sets `rx_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, high when idle |
| baud_tick | input | 1 | One-cycle enable, 16 per bit time |
| cfg_word8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| cfg_par_en | input | 1 | 1 adds a parity bit after the data bits |
| cfg_sleep | input | 1 | 1 puts the receiver to sleep |
| rd_stb | input | 1 | Data-read strobe, clears the ready flag |
| cfg_wr_stb | input | 1 | Configuration-write strobe, clears the status flag |
| rx_data | output | 8 | Last good character |
| rx_par | output | 1 | Parity bit received with that character |
| rx_ready | output | 1 | A character is waiting to be read |
| rx_status | output | 1 | Framing error when awake, line activity when asleep |

## Verification
Two events can land on the ready flag in the same cycle: a character completing and a read strobe clearing the flag. The bench holds `rd_stb` high for the whole of a frame, so the two are certain to coincide in the completion cycle. It then counts the cycles in which `rx_ready` is seen high. Exactly one such cycle, together with the new character on `rx_data`, shows that completion wins the cycle and that the held strobe clears the flag again on the next one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   typedef enum logic [2:0] {
      RX_HUNT  = 3'd0,
      RX_START = 3'd1,
      RX_DATA  = 3'd2,
      RX_PAR   = 3'd3,
      RX_STOP  = 3'd4
   } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic line_s,
   output logic line_edge
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rx_line_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], line_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign line_s    = chain_q[STAGES-1];
   assign line_edge = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/rx_framer.sv
module rx_framer
   import serial_rx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int WMAX        = 8,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            enable,
   input  logic            line_s,
   input  logic            cfg_long,
   input  logic            cfg_par,
   output logic            char_good,
   output logic            char_bad,
   output logic [WMAX-1:0] char_data,
   output logic            char_par
);
   localparam int CW   = $clog2(OSR);
   localparam int IW   = $clog2(WMAX);
   localparam int HALF = OSR / 2;

   rx_state_e         state_q;
   logic [CW-1:0]     cnt_q;
   logic [IW-1:0]     idx_q;
   logic [WMAX-1:0]   sh_q;
   logic              par_q;
   logic              long_q;
   logic              pen_q;
   logic              pen_eff;
   logic              last_bit;
   logic              bit_end;

   generate
      if (PAR_SUPPORT) begin : g_par
         assign pen_eff = cfg_par;
      end else begin : g_nopar
         assign pen_eff = 1'b0;
      end
   endgenerate

   always_comb begin
      last_bit = long_q ? (idx_q == IW'(WMAX - 1)) : (idx_q == IW'(WMAX - 2));
      bit_end  = tick && (cnt_q == CW'(OSR - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_HUNT;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         par_q   <= 1'b0;
         long_q  <= 1'b0;
         pen_q   <= 1'b0;
      end else if (!enable) begin
         state_q <= RX_HUNT;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            RX_HUNT: begin
               if (tick && !line_s) begin
                  state_q <= RX_START;
                  cnt_q   <= '0;
                  idx_q   <= '0;
                  par_q   <= 1'b0;
                  long_q  <= cfg_long;
                  pen_q   <= pen_eff;
               end
            end
            RX_START: begin
               if (tick) begin
                  if (cnt_q == CW'(HALF - 1)) begin
                     cnt_q   <= '0;
                     state_q <= line_s ? RX_HUNT : RX_DATA;
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            RX_DATA: begin
               if (bit_end) begin
                  cnt_q <= '0;
                  sh_q  <= {line_s, sh_q[WMAX-1:1]};
                  if (last_bit) begin
                     state_q <= pen_q ? RX_PAR : RX_STOP;
                  end else begin
                     idx_q <= idx_q + IW'(1);
                  end
               end else if (tick) begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            RX_PAR: begin
               if (bit_end) begin
                  cnt_q   <= '0;
                  par_q   <= line_s;
                  state_q <= RX_STOP;
               end else if (tick) begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            RX_STOP: begin
               if (bit_end) begin
                  cnt_q   <= '0;
                  state_q <= RX_HUNT;
               end else if (tick) begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= RX_HUNT;
         endcase
      end
   end

   assign char_good = enable && (state_q == RX_STOP) && bit_end && line_s;
   assign char_bad  = enable && (state_q == RX_STOP) && bit_end && !line_s;
   assign char_data = long_q ? sh_q : {1'b0, sh_q[WMAX-1:1]};
   assign char_par  = par_q;
endmodule

// File: rtl/rx_hold.sv
module rx_hold #(
   parameter int WMAX = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sleep,
   input  logic            rd_stb,
   input  logic            wr_stb,
   input  logic            line_edge,
   input  logic            char_good,
   input  logic            char_bad,
   input  logic [WMAX-1:0] char_data,
   input  logic            char_par,
   output logic [WMAX-1:0] data_q,
   output logic            par_q,
   output logic            ready_q,
   output logic            stat_q
);
   logic sleep_q;
   logic sleep_rise;

   assign sleep_rise = sleep && !sleep_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b0;
         data_q  <= '0;
         par_q   <= 1'b0;
         ready_q <= 1'b0;
         stat_q  <= 1'b0;
      end else begin
         sleep_q <= sleep;
         if (sleep_rise) begin
            data_q  <= '0;
            par_q   <= 1'b0;
            ready_q <= 1'b0;
            stat_q  <= line_edge;
         end else begin
            if (char_good) begin
               data_q  <= char_data;
               par_q   <= char_par;
               ready_q <= 1'b1;
            end else if (rd_stb) begin
               ready_q <= 1'b0;
            end
            if (sleep) begin
               if (line_edge) stat_q <= 1'b1;
               else if (wr_stb) stat_q <= 1'b0;
            end else begin
               if (char_bad) stat_q <= 1'b1;
               else if (char_good || wr_stb) stat_q <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame #(
   parameter int OSR         = 16,
   parameter int WMAX        = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit PAR_SUPPORT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_line,
   input  logic            baud_tick,
   input  logic            cfg_word8,
   input  logic            cfg_par_en,
   input  logic            cfg_sleep,
   input  logic            rd_stb,
   input  logic            cfg_wr_stb,
   output logic [WMAX-1:0] rx_data,
   output logic            rx_par,
   output logic            rx_ready,
   output logic            rx_status
);
   generate
      if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
         $error("serial_rx_frame: OSR must be a power of two, at least 4");
      end
      if (WMAX < 2) begin : g_bad_wmax
         $error("serial_rx_frame: WMAX must be at least 2");
      end
   endgenerate

   logic            line_s;
   logic            line_edge;
   logic            char_good;
   logic            char_bad;
   logic [WMAX-1:0] char_data;
   logic            char_par;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (rx_line),
      .line_s    (line_s),
      .line_edge (line_edge)
   );

   rx_framer #(.OSR(OSR), .WMAX(WMAX), .PAR_SUPPORT(PAR_SUPPORT)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .enable    (!cfg_sleep),
      .line_s    (line_s),
      .cfg_long  (cfg_word8),
      .cfg_par   (cfg_par_en),
      .char_good (char_good),
      .char_bad  (char_bad),
      .char_data (char_data),
      .char_par  (char_par)
   );

   rx_hold #(.WMAX(WMAX)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .sleep     (cfg_sleep),
      .rd_stb    (rd_stb),
      .wr_stb    (cfg_wr_stb),
      .line_edge (line_edge),
      .char_good (char_good),
      .char_bad  (char_bad),
      .char_data (char_data),
      .char_par  (char_par),
      .data_q    (rx_data),
      .par_q     (rx_par),
      .ready_q   (rx_ready),
      .stat_q    (rx_status)
   );
endmodule

// File: rtl/serial_rx_frame_chk.sv
module serial_rx_frame_chk #(
   parameter int WMAX = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_sleep,
   input logic            rd_stb,
   input logic            cfg_wr_stb,
   input logic            rx_ready,
   input logic            rx_status,
   input logic [WMAX-1:0] rx_data,
   input logic            rx_par,
   input logic            line_edge,
   input logic            char_good,
   input logic            char_bad
);
   p_char_sets_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      char_good |=> rx_ready);

   p_bad_stop_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      char_bad |=> rx_status);

   p_bad_stop_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      char_bad && !cfg_sleep |=> $stable(rx_data));

   p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_status && !char_good && !cfg_wr_stb && !cfg_sleep |=> rx_status);

   p_cfg_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_stb && !char_bad && !cfg_sleep |=> !rx_status);

   p_read_clears_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb && !char_good |=> !rx_ready);

   p_sleep_entry_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_sleep) |=> !rx_ready && (rx_data == '0) && !rx_par);

   p_asleep_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_sleep |=> !rx_ready);

   p_activity_sets_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      line_edge && cfg_sleep |=> rx_status);
endmodule

bind serial_rx_frame serial_rx_frame_chk #(.WMAX(WMAX)) u_chk (.*);

// File: tb/serial_rx_frame_bench.sv
module serial_rx_frame_bench;
   localparam int TDIV = 2;
   localparam int OSR  = 16;
   localparam int BITC = TDIV * OSR;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_line = 1'b1;
   logic       baud_tick = 1'b0;
   logic       cfg_word8 = 1'b1;
   logic       cfg_par_en = 1'b0;
   logic       cfg_sleep = 1'b0;
   logic       rd_stb = 1'b0;
   logic       cfg_wr_stb = 1'b0;
   logic [7:0] rx_data;
   logic       rx_par;
   logic       rx_ready;
   logic       rx_status;

   int checks = 0;
   int errors = 0;
   int tdiv_cnt = 0;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (tdiv_cnt == TDIV - 1) begin
         tdiv_cnt  <= 0;
         baud_tick <= 1'b1;
      end else begin
         tdiv_cnt  <= tdiv_cnt + 1;
         baud_tick <= 1'b0;
      end
   end

   serial_rx_frame u_serial_rx_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_line    (rx_line),
      .baud_tick  (baud_tick),
      .cfg_word8  (cfg_word8),
      .cfg_par_en (cfg_par_en),
      .cfg_sleep  (cfg_sleep),
      .rd_stb     (rd_stb),
      .cfg_wr_stb (cfg_wr_stb),
      .rx_data    (rx_data),
      .rx_par     (rx_par),
      .rx_ready   (rx_ready),
      .rx_status  (rx_status)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                             input bit pbit, input bit stop_ok);
      rx_line = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rx_line = d[i];
         repeat (BITC) @(negedge clk);
      end
      if (pen) begin
         rx_line = pbit;
         repeat (BITC) @(negedge clk);
      end
      if (stop_ok) begin
         rx_line = 1'b1;
         repeat (BITC) @(negedge clk);
      end else begin
         rx_line = 1'b0;
         repeat (BITC * 3 / 4) @(negedge clk);
         rx_line = 1'b1;
         repeat (BITC * 2) @(negedge clk);
      end
   endtask

   task automatic pulse_rd();
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_wr();
      cfg_wr_stb = 1'b1;
      @(negedge clk);
      cfg_wr_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk(rx_ready == 1'b0, "R1 ready", rx_ready, 0);
      chk(rx_status == 1'b0, "R1 status", rx_status, 0);
      chk(rx_par == 1'b0, "R1 parity", rx_par, 0);
      chk(rx_data == 8'h00, "R1 data", rx_data, 0);
   endtask

   task automatic t_basic8();
      cfg_word8 = 1'b1; cfg_par_en = 1'b0;
      send_frame(8'hA1, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_ready == 1'b1, "R2 ready", rx_ready, 1);
      chk(rx_data == 8'hA1, "R2 data", rx_data, 8'hA1);
      chk(rx_par == 1'b0, "R4 parity off reads 0", rx_par, 0);
      pulse_rd();
      chk(rx_ready == 1'b0, "R10 read clears ready", rx_ready, 0);
      chk(rx_data == 8'hA1, "R10 read keeps data", rx_data, 8'hA1);
   endtask

   task automatic t_word7();
      cfg_word8 = 1'b0; cfg_par_en = 1'b0;
      send_frame(8'hFF, 7, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'h7F, "R3 seven bits, top 0", rx_data, 8'h7F);
      pulse_rd();
      send_frame(8'h35, 7, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'h35, "R3 seven-bit pattern", rx_data, 8'h35);
      pulse_rd();
      cfg_word8 = 1'b1;
   endtask

   task automatic t_parity();
      cfg_word8 = 1'b1; cfg_par_en = 1'b1;
      send_frame(8'h5A, 8, 1'b1, 1'b1, 1'b1);
      chk(rx_ready == 1'b1, "R4 wrong parity accepted", rx_ready, 1);
      chk(rx_data == 8'h5A, "R4 data with parity", rx_data, 8'h5A);
      chk(rx_par == 1'b1, "R4 parity bit 1", rx_par, 1);
      pulse_rd();
      cfg_word8 = 1'b0;
      send_frame(8'h6B, 7, 1'b1, 1'b0, 1'b1);
      chk(rx_data == 8'h6B, "R4 seven-bit data with parity", rx_data, 8'h6B);
      chk(rx_par == 1'b0, "R4 parity bit 0", rx_par, 0);
      pulse_rd();
      cfg_word8 = 1'b1; cfg_par_en = 1'b0;
   endtask

   task automatic t_false_start();
      rx_line = 1'b0;
      repeat (BITC / 4) @(negedge clk);
      rx_line = 1'b1;
      repeat (BITC * 12) @(negedge clk);
      chk(rx_ready == 1'b0, "R5 false start no ready", rx_ready, 0);
      chk(rx_data == 8'h6B, "R5 false start data kept", rx_data, 8'h6B);
   endtask

   task automatic t_frame_err();
      send_frame(8'hC4, 8, 1'b0, 1'b0, 1'b1);
      send_frame(8'h3C, 8, 1'b0, 1'b0, 1'b0);
      chk(rx_status == 1'b1, "R6 bad stop sets status", rx_status, 1);
      chk(rx_ready == 1'b1, "R6 ready unchanged", rx_ready, 1);
      chk(rx_data == 8'hC4, "R6 data not loaded", rx_data, 8'hC4);
      pulse_rd();
      chk(rx_status == 1'b1, "R7 status survives read", rx_status, 1);
      send_frame(8'h96, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_status == 1'b0, "R7 good char clears status", rx_status, 0);
      chk(rx_data == 8'h96, "R6 receiver hunts again", rx_data, 8'h96);
      pulse_rd();
   endtask

   task automatic t_wr_clear();
      send_frame(8'h00, 8, 1'b0, 1'b0, 1'b0);
      chk(rx_status == 1'b1, "R8 status set before write", rx_status, 1);
      pulse_wr();
      chk(rx_status == 1'b0, "R8 config write clears status", rx_status, 0);
   endtask

   task automatic t_back2back();
      logic [7:0] got1, got2;
      got1 = '0; got2 = '0;
      fork
         begin
            send_frame(8'h81, 8, 1'b0, 1'b0, 1'b1);
            send_frame(8'h7E, 8, 1'b0, 1'b0, 1'b1);
         end
         begin
            do @(negedge clk); while (!rx_ready);
            got1 = rx_data;
            pulse_rd();
            do @(negedge clk); while (!rx_ready);
            got2 = rx_data;
         end
      join
      chk(got1 == 8'h81, "R9 first of back-to-back", got1, 8'h81);
      chk(got2 == 8'h7E, "R9 second of back-to-back", got2, 8'h7E);
      pulse_rd();
   endtask

   task automatic t_read_collide();
      int  hi;
      bit  fin;
      hi = 0; fin = 1'b0;
      rd_stb = 1'b1;
      fork
         begin
            send_frame(8'hE7, 8, 1'b0, 1'b0, 1'b1);
            fin = 1'b1;
         end
         begin
            while (!fin) begin
               @(negedge clk);
               if (rx_ready) hi++;
            end
         end
      join
      rd_stb = 1'b0;
      @(negedge clk);
      chk(hi == 1, "R10 completion wins over held read", hi, 1);
      chk(rx_data == 8'hE7, "R10 data loaded under read", rx_data, 8'hE7);
      chk(rx_ready == 1'b0, "R10 held read clears after", rx_ready, 0);
   endtask

   task automatic t_sleep();
      send_frame(8'h55, 8, 1'b0, 1'b0, 1'b1);
      send_frame(8'h11, 8, 1'b0, 1'b0, 1'b0);
      cfg_sleep = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(rx_ready == 1'b0, "R11 sleep clears ready", rx_ready, 0);
      chk(rx_data == 8'h00, "R11 sleep clears data", rx_data, 0);
      chk(rx_par == 1'b0, "R11 sleep clears parity", rx_par, 0);
      chk(rx_status == 1'b0, "R11 sleep clears status", rx_status, 0);
      rx_line = 1'b0;
      repeat (5) @(negedge clk);
      chk(rx_status == 1'b1, "R12 activity sets status", rx_status, 1);
      rx_line = 1'b1;
      repeat (5) @(negedge clk);
      pulse_wr();
      chk(rx_status == 1'b0, "R8 write clears activity", rx_status, 0);
      send_frame(8'hA5, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_ready == 1'b0, "R11 no receive asleep", rx_ready, 0);
      chk(rx_data == 8'h00, "R11 data stays clear asleep", rx_data, 0);
      cfg_sleep = 1'b0;
      pulse_wr();
      send_frame(8'h3E, 8, 1'b0, 1'b0, 1'b1);
      chk(rx_data == 8'h3E, "R2 receive after wake", rx_data, 8'h3E);
      pulse_rd();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      t_reset();
      t_basic8();
      t_word7();
      t_parity();
      t_false_start();
      t_frame_err();
      t_wr_clear();
      t_back2back();
      t_read_collide();
      t_sleep();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule